// File: doc/BRIEF.md
# Mixed-Depth Pixel Source Selector

This block is the per-pixel scan stage of a framebuffer that stores each pixel in three parallel planes: an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. On a start pulse it walks a raster of up to 1024 by 768 pixels in row order. It issues one plane address per cycle, and all three planes share that address. For every pixel it inspects the top byte of the control word and then emits one of two colours: the 24-bit direct colour, or the colour that the palette returns for the 8-bit index.

The planes are read through a synchronous port, and the data returns one cycle after the address. The palette is a separate lookup port that also answers one cycle after its index. The direct colour is held in a register for that extra cycle, so pixels leave in raster order, one per cycle, with a frame-start flag on the first pixel and an end-of-line flag on the last pixel of every row. Active width and height are latched at the start of a frame. A build-time parameter removes direct colour altogether for an 8-bit-only configuration.

Top module: `mixdepth_scanout`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `pix_rd` and `pal_rd_en` are low.
- R2: A frame emits exactly width times height pixels in row order. Pixel (x, y) is read at plane address y*1024 + x, because every row uses a stride of 1024 whatever the active width.
- R3: A pixel whose control word has bits 31:24 equal to 0x03 outputs the direct word's bits 23:0, with red in 23:16, green in 15:8 and blue in 7:0. The direct word's top byte has no effect.
- R4: Every other control value selects the indexed path. `pal_rd_en` is raised with `pal_rd_idx` equal to the pixel's index byte, and the output is the 24-bit palette answer, which arrives one cycle later.
- R5: With `DIRECT_EN` = 0, every pixel takes the indexed path, including pixels whose control byte is 0x03.
- R6: `out_sof` is high only on the first pixel of a frame. `out_eol` is high only on the last pixel (x = width-1) of each row.
- R7: The first pixel appears at the output three clock edges after the edge that samples `frame_start`. Thereafter one pixel leaves per cycle, with no gap and in order.
- R8: A `frame_start` that arrives while a frame is running is ignored. Width and height changes take effect only at the next accepted start.
- R9: A start with a width of zero or a height of zero produces no pixels and no plane reads.
- R10: A requested width above 1024 is clamped to 1024, and a requested height above 768 is clamped to 768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Request to start a frame; honoured only when idle |
| act_width | input | 11 | Active pixels per row, clamped to 1024 |
| act_height | input | 10 | Active rows, clamped to 768 |
| pix_rd | output | 1 | Plane read strobe, one per pixel |
| pix_addr | output | 20 | Shared pixel address for all three planes |
| idx_rdata | input | 8 | Index-plane byte, one cycle after the address |
| dir_rdata | input | 32 | Direct-plane word, one cycle after the address |
| ctl_rdata | input | 32 | Control-plane word, one cycle after the address |
| pal_rd_en | output | 1 | Palette lookup strobe |
| pal_rd_idx | output | 8 | Palette entry to look up |
| pal_rdata | input | 24 | Palette colour, one cycle after the lookup |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Output colour, red in 23:16 |
| out_sof | output | 1 | First pixel of the frame |
| out_eol | output | 1 | Last pixel of the row |

## Verification
The hardest situation to reach is a run of pixels that switch between direct and indexed colour from one pixel to the next. That is the only case that can expose a palette strobe left high, missing, or paired with the wrong pixel, and the only case that can expose a direct colour leaving in the wrong slot. The bench's palette model keeps its last answer whenever the strobe is low, so a missing strobe appears as a stale colour. In the mixed mode the control plane derives its selector from bits of both x and y, so the two kinds of pixel interleave along every row. The last row of a clamped 768-row frame and a full 1024-pixel row are run to reach the extreme plane addresses.

// File: rtl/mds_pkg.sv
package mds_pkg;

    // Control-plane tag value that selects direct colour.
    localparam logic [7:0] DIRECT_TAG = 8'h03;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef struct packed {
        logic valid;
        logic sof;
        logic eol;
    } pix_meta_t;

    function automatic logic tag_is_direct(input logic [7:0] tag);
        return tag == DIRECT_TAG;
    endfunction

    function automatic rgb_t unpack_direct(input logic [23:0] low_bits);
        return rgb_t'(low_bits);
    endfunction

endpackage

// File: rtl/mds_raster_walker.sv
module mds_raster_walker
    import mds_pkg::*;
#(
    parameter int MAX_W  = 1024,
    parameter int MAX_H  = 768,
    parameter int STRIDE = 1024,
    parameter int WB     = 11,
    parameter int HB     = 10,
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WB-1:0]     req_w,
    input  logic [HB-1:0]     req_h,
    output logic              rd,
    output logic [ADDR_W-1:0] addr,
    output pix_meta_t         meta
);

    logic          running;
    logic [WB-1:0] x, wl, w_eff;
    logic [HB-1:0] y, hl, h_eff;
    logic          last_col, last_row;

    assign w_eff    = (req_w > WB'(MAX_W)) ? WB'(MAX_W) : req_w;
    assign h_eff    = (req_h > HB'(MAX_H)) ? HB'(MAX_H) : req_h;
    assign last_col = (x == wl - WB'(1));
    assign last_row = (y == hl - HB'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            x       <= '0;
            y       <= '0;
            wl      <= '0;
            hl      <= '0;
        end else if (!running) begin
            if (start && (w_eff != '0) && (h_eff != '0)) begin
                running <= 1'b1;
                x       <= '0;
                y       <= '0;
                wl      <= w_eff;
                hl      <= h_eff;
            end
        end else if (last_col) begin
            x <= '0;
            if (last_row) running <= 1'b0;
            else          y       <= y + HB'(1);
        end else begin
            x <= x + WB'(1);
        end
    end

    assign rd        = running;
    assign addr      = ADDR_W'(y) * ADDR_W'(STRIDE) + ADDR_W'(x);
    assign meta.valid = running;
    assign meta.sof   = running && (x == '0) && (y == '0);
    assign meta.eol   = running && last_col;

    // R2: the end of a row that is not the last moves to column 0 of the next row
    a_r2_next_row: assert property (@(posedge clk) disable iff (rst)
        (running && last_col && !last_row) |=> (running && x == '0 && y == $past(y) + HB'(1)));

    // R8: a running frame keeps going and keeps its latched size
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (running && !(last_col && last_row)) |=> (running && wl == $past(wl) && hl == $past(hl)));

    // R10: latched size never exceeds the maximum raster
    a_r10_bounds: assert property (@(posedge clk) disable iff (rst)
        running |-> (wl <= WB'(MAX_W) && hl <= HB'(MAX_H) && x < wl && y < hl));

endmodule

// File: rtl/mds_colour_select.sv
module mds_colour_select
    import mds_pkg::*;
#(
    parameter bit DIRECT_EN = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  pix_meta_t meta_in,
    input  logic [7:0]  idx_byte,
    input  logic [31:0] dir_word,
    input  logic [31:0] ctl_word,
    output logic        pal_en,
    output logic [7:0]  pal_idx,
    output pix_meta_t   meta_out,
    output logic        dir_sel_out,
    output rgb_t        dir_rgb_out
);

    pix_meta_t m1;
    logic      take_dir;

    // Stage 1: metadata aligned with plane data returning from memory.
    always_ff @(posedge clk) begin
        if (rst) m1 <= '0;
        else     m1 <= meta_in;
    end

    generate
        if (DIRECT_EN) begin : g_mixed
            logic unused_bits;
            assign unused_bits = ^{ctl_word[23:0], dir_word[31:24]};
            assign take_dir    = tag_is_direct(ctl_word[31:24]);
        end else begin : g_index_only
            logic unused_bits;
            assign unused_bits = ^{ctl_word, dir_word[31:24]};
            assign take_dir    = 1'b0;
        end
    endgenerate

    assign pal_idx = idx_byte;
    assign pal_en  = m1.valid && !take_dir;

    // Stage 2: direct colour delayed to match the palette latency.
    always_ff @(posedge clk) begin
        if (rst) begin
            meta_out    <= '0;
            dir_sel_out <= 1'b0;
            dir_rgb_out <= '0;
        end else begin
            meta_out    <= m1;
            dir_sel_out <= take_dir;
            dir_rgb_out <= unpack_direct(dir_word[23:0]);
        end
    end

    // R4: a palette strobe is followed by an indexed pixel in stage 2
    a_r4_pal_follows: assert property (@(posedge clk) disable iff (rst)
        pal_en |=> (meta_out.valid && !dir_sel_out));

endmodule

// File: rtl/mds_out_stage.sv
module mds_out_stage
    import mds_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pix_meta_t meta_in,
    input  logic      dir_sel,
    input  rgb_t      dir_rgb,
    input  rgb_t      pal_rgb,
    output logic      out_valid,
    output rgb_t      out_rgb,
    output logic      out_sof,
    output logic      out_eol
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= meta_in.valid;
            out_sof   <= meta_in.sof;
            out_eol   <= meta_in.eol;
            out_rgb   <= dir_sel ? dir_rgb : pal_rgb;
        end
    end

    // R6: a stream always begins with the frame-start pixel
    a_r6_first_is_sof: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_sof);

    // R6: frame start is a single pixel
    a_r6_sof_single: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sof) |=> !out_sof);

    // R7: pixels within a row leave back to back
    a_r7_row_contiguous: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eol) |=> out_valid);

endmodule

// File: rtl/mixdepth_scanout.sv
module mixdepth_scanout
    import mds_pkg::*;
#(
    parameter int  MAX_W     = 1024,
    parameter int  MAX_H     = 768,
    parameter bit  DIRECT_EN = 1'b1,
    localparam int STRIDE    = MAX_W,
    localparam int WB        = $clog2(MAX_W + 1),
    localparam int HB        = $clog2(MAX_H + 1),
    localparam int ADDR_W    = $clog2(STRIDE * MAX_H)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [WB-1:0]     act_width,
    input  logic [HB-1:0]     act_height,
    output logic              pix_rd,
    output logic [ADDR_W-1:0] pix_addr,
    input  logic [7:0]        idx_rdata,
    input  logic [31:0]       dir_rdata,
    input  logic [31:0]       ctl_rdata,
    output logic              pal_rd_en,
    output logic [7:0]        pal_rd_idx,
    input  logic [23:0]       pal_rdata,
    output logic              out_valid,
    output logic [23:0]       out_rgb,
    output logic              out_sof,
    output logic              out_eol
);

    pix_meta_t meta0, meta2;
    logic      dir_sel2;
    rgb_t      dir_rgb2;
    rgb_t      rgb_q;

    mds_raster_walker #(
        .MAX_W (MAX_W),
        .MAX_H (MAX_H),
        .STRIDE(STRIDE),
        .WB    (WB),
        .HB    (HB),
        .ADDR_W(ADDR_W)
    ) u_walk (
        .clk  (clk),
        .rst  (rst),
        .start(frame_start),
        .req_w(act_width),
        .req_h(act_height),
        .rd   (pix_rd),
        .addr (pix_addr),
        .meta (meta0)
    );

    mds_colour_select #(
        .DIRECT_EN(DIRECT_EN)
    ) u_sel (
        .clk        (clk),
        .rst        (rst),
        .meta_in    (meta0),
        .idx_byte   (idx_rdata),
        .dir_word   (dir_rdata),
        .ctl_word   (ctl_rdata),
        .pal_en     (pal_rd_en),
        .pal_idx    (pal_rd_idx),
        .meta_out   (meta2),
        .dir_sel_out(dir_sel2),
        .dir_rgb_out(dir_rgb2)
    );

    mds_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .meta_in  (meta2),
        .dir_sel  (dir_sel2),
        .dir_rgb  (dir_rgb2),
        .pal_rgb  (rgb_t'(pal_rdata)),
        .out_valid(out_valid),
        .out_rgb  (rgb_q),
        .out_sof  (out_sof),
        .out_eol  (out_eol)
    );

    assign out_rgb = rgb_q;

    // Cycles since reset, saturating, so the latency check never looks before reset.
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)               age <= '0;
        else if (age != 2'd3)  age <= age + 2'd1;
    end

    // R7: each output pixel appears exactly three edges after its plane read
    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_valid == $past(pix_rd, 3)));

    // R9: no palette strobe without an active pixel in flight
    a_r9_no_idle_lookup: assert property (@(posedge clk) disable iff (rst)
        pal_rd_en |-> $past(pix_rd));

endmodule

// File: tb/mixdepth_scanout_test.sv
module mixdepth_scanout_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic [10:0] act_width = '0;
    logic [9:0]  act_height = '0;

    logic        pix_rd, pix_rd8;
    logic [19:0] pix_addr, pix_addr8;
    logic [7:0]  idx_q;
    logic [31:0] dir_q, ctl_q;
    logic        pal_rd_en, pal_rd_en8;
    logic [7:0]  pal_rd_idx, pal_rd_idx8;
    logic [23:0] pal_q, pal8_q;
    logic        out_valid, out_sof, out_eol;
    logic [23:0] out_rgb;
    logic        out8_valid, out8_sof, out8_eol;
    logic [23:0] out8_rgb;

    int n_tests = 0;
    int n_fail  = 0;
    int mode    = 0;
    int cw = 1, ch = 1;
    int ex = 0, ey = 0, seen = 0;

    always #2 clk = ~clk;

    mixdepth_scanout uut (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .act_width(act_width), .act_height(act_height),
        .pix_rd(pix_rd), .pix_addr(pix_addr),
        .idx_rdata(idx_q), .dir_rdata(dir_q), .ctl_rdata(ctl_q),
        .pal_rd_en(pal_rd_en), .pal_rd_idx(pal_rd_idx), .pal_rdata(pal_q),
        .out_valid(out_valid), .out_rgb(out_rgb), .out_sof(out_sof), .out_eol(out_eol)
    );

    mixdepth_scanout #(.DIRECT_EN(1'b0)) uut8 (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .act_width(act_width), .act_height(act_height),
        .pix_rd(pix_rd8), .pix_addr(pix_addr8),
        .idx_rdata(idx_q), .dir_rdata(dir_q), .ctl_rdata(ctl_q),
        .pal_rd_en(pal_rd_en8), .pal_rd_idx(pal_rd_idx8), .pal_rdata(pal8_q),
        .out_valid(out8_valid), .out_rgb(out8_rgb), .out_sof(out8_sof), .out_eol(out8_eol)
    );

    function automatic logic [7:0] idx_fn(input logic [19:0] a);
        return a[7:0] ^ a[17:10];
    endfunction

    function automatic logic [31:0] dir_fn(input logic [19:0] a);
        return {~a[7:0], {4'h9, a} ^ 24'h35C3A5};
    endfunction

    function automatic logic [31:0] ctl_fn(input logic [19:0] a, input int m);
        logic [7:0] tag;
        if (m == 1)      tag = 8'h03;
        else if (m == 2) tag = 8'h30;
        else begin
            case (a[1:0] ^ a[11:10])
                2'd0:    tag = 8'h03;
                2'd1:    tag = 8'h02;
                2'd2:    tag = 8'h83;
                default: tag = 8'h03;
            endcase
        end
        return {tag, 4'h0, a};
    endfunction

    function automatic logic [23:0] pal_fn(input logic [7:0] i);
        return {i ^ 8'h5A, ~i, i + 8'd17};
    endfunction

    // Synchronous plane memory and palettes: answer one cycle after the request.
    always @(posedge clk) begin
        if (pix_rd) begin
            idx_q <= idx_fn(pix_addr);
            dir_q <= dir_fn(pix_addr);
            ctl_q <= ctl_fn(pix_addr, mode);
        end
        if (pal_rd_en)  pal_q  <= pal_fn(pal_rd_idx);
        if (pal_rd_en8) pal8_q <= pal_fn(pal_rd_idx8);
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Output monitor: compares every pixel against the raster position it must carry.
    always @(negedge clk) begin
        if (!rst && (out_valid || out8_valid)) begin
            logic [19:0] a;
            logic [31:0] c;
            logic [23:0] exp_rgb;
            bit          is_dir;
            a = 20'(ey * 1024 + ex);
            c = ctl_fn(a, mode);
            is_dir = (c[31:24] == 8'h03);
            exp_rgb = is_dir ? dir_fn(a)[23:0] : pal_fn(idx_fn(a));
            chk(out_valid, "R2 pixel valid", 32'(out_valid), 32'd1);
            if (is_dir) chk(out_rgb == exp_rgb, "R3 direct colour", 32'(out_rgb), 32'(exp_rgb));
            else        chk(out_rgb == exp_rgb, "R4 indexed colour", 32'(out_rgb), 32'(exp_rgb));
            chk(out_sof == (ex == 0 && ey == 0), "R6 sof", 32'(out_sof), 32'(ex == 0 && ey == 0));
            chk(out_eol == (ex == cw - 1), "R6 eol", 32'(out_eol), 32'(ex == cw - 1));
            chk(out8_valid && out8_rgb == pal_fn(idx_fn(a)), "R5 index-only colour",
                32'(out8_rgb), 32'(pal_fn(idx_fn(a))));
            seen++;
            if (ex == cw - 1) begin ex = 0; ey++; end
            else ex++;
        end
    end

    task automatic arm(input int w, input int h, input int m);
        mode = m;
        cw = (w > 1024) ? 1024 : w;
        ch = (h > 768) ? 768 : h;
        ex = 0; ey = 0; seen = 0;
        act_width  = 11'(w);
        act_height = 10'(h);
    endtask

    task automatic run_frame(input int w, input int h, input int m, input int n_exp, input string rq);
        @(negedge clk);
        arm(w, h, m);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (n_exp + 8) @(negedge clk);
        chk(seen == n_exp, rq, 32'(seen), 32'(n_exp));
    endtask

    // Stimulus table: width, height, control mode (0 mixed, 1 all direct, 2 all indexed), pixel count.
    localparam int NV = 7;
    localparam int VW[NV] = '{4, 1, 7, 1024, 3, 16, 5};
    localparam int VH[NV] = '{3, 1, 5, 2,    4, 1,  9};
    localparam int VM[NV] = '{0, 0, 0, 0,    1, 2,  0};
    localparam int VN[NV] = '{12, 1, 35, 2048, 12, 16, 45};

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int lat;
        repeat (4) @(negedge clk);
        // R1: reset state while reset is held
        chk(!out_valid && !pix_rd && !pal_rd_en, "R1 during reset",
            {29'd0, out_valid, pix_rd, pal_rd_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!out_valid && !pix_rd && !pal_rd_en, "R1 after reset",
            {29'd0, out_valid, pix_rd, pal_rd_en}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_frame(VW[i], VH[i], VM[i], VN[i], "R2 pixel count");
        end

        // R7: latency from the start-sampling edge to the first pixel
        @(negedge clk);
        arm(2, 1, 1);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        lat = 0;
        while (!out_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 3, "R7 first-pixel latency", 32'(lat), 32'd3);
        repeat (6) @(negedge clk);
        chk(seen == 2, "R7 pixel count", 32'(seen), 32'd2);

        // R8: a start during a running frame is ignored and the size stays latched
        @(negedge clk);
        arm(5, 3, 0);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (4) @(negedge clk);
        act_width = 11'd2;
        act_height = 10'd1;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (20) @(negedge clk);
        chk(seen == 15, "R8 restart ignored", 32'(seen), 32'd15);

        // R9: empty frames
        run_frame(0, 5, 0, 0, "R9 zero width");
        run_frame(5, 0, 0, 0, "R9 zero height");
        chk(!pix_rd, "R9 no plane read", 32'(pix_rd), 32'd0);

        // R10: clamping, including the last row of the full-height raster
        run_frame(2000, 1, 0, 1024, "R10 width clamp");
        run_frame(1, 1000, 0, 768, "R10 height clamp");
        run_frame(1023, 1, 2, 1023, "R2 wide indexed row");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule